// File: doc/BRIEF.md
# CPU Bus Address Decoder

This block sits on the 16-bit address bus of an 8-bit processor and sorts every bus cycle into one of four regions. The lowest eighth of the map reaches a 2 KB work RAM held inside the block. Because the RAM is indexed by the low eleven address bits, it repeats every 0x800 bytes. The next eighth is a window onto eight graphics-processor registers, selected by the low three address bits, so the window repeats every 8 bytes. A short I/O span follows. In that span only one address does anything: a write there launches a sprite-memory DMA transfer and hands over the source page byte. Everything from 0x4020 upward passes through unchanged to a cartridge mapper port.

Register and mapper traffic leaves the block as single-cycle strobes, one cycle after the bus cycle that caused it. The register side has a separate one-hot strobe for reads and for writes. Each register index has its own rule for which directions are legal. An access in a direction that index does not allow produces no strobe. It sets a sticky error flag, and a read of that kind returns zero.

The bus has no ready signal: the decoder accepts every cycle in which `bus_valid` is high and never applies back-pressure. Read data is returned with `bus_rvalid` in the cycle after the request. The graphics registers and the mapper must place their data on `reg_rdata` / `map_rdata` during the cycle in which their strobe is high.

Top module: `cpu_bus_decoder`

## Requirements
- R1: A bus cycle with address below 0x2000 accesses the internal 2 KB RAM at index addr[10:0]. Writes take effect at the clock edge, and a read returns the stored byte on `bus_rdata` one cycle later, so the addresses A, A+0x800, A+0x1000 and A+0x1800 alias.
- R2: A read in 0x2000–0x3FFF with addr[2:0] equal to 2, 4 or 7 raises bit addr[2:0] of `reg_rd_stb` for exactly the next cycle. In that cycle `bus_rdata` equals `reg_rdata`.
- R3: A write in 0x2000–0x3FFF with addr[2:0] equal to 0, 1, 3, 4, 5, 6 or 7 raises bit addr[2:0] of `reg_wr_stb` for exactly the next cycle, with the written byte on `reg_wdata`. `reg_wdata` holds its value until the next such write.
- R4: A read of register index 0, 1, 3, 5 or 6, or a write to index 2, raises no register strobe. It sets `err_flag` from the next cycle onward until reset, and a read of that kind returns 0x00.
- R5: A write to exactly 0x4014 raises `dma_start` for the next cycle only, with the written byte on `dma_page`. `dma_page` holds its value until the next such write.
- R6: Reads in 0x4000–0x401F return 0x00. Writes there other than to 0x4014 raise no strobe, no mapper request and no DMA start, and leave RAM unchanged.
- R7: Any access at 0x4020 or above raises `map_req` for the next cycle, with the unchanged address on `map_addr`, the direction on `map_write` (1 = write) and the bus byte on `map_wdata`. A read returns `map_rdata` in that cycle. The map outputs hold between requests.
- R8: A cycle with `bus_valid` low raises no strobe, no `map_req`, no `dma_start` and no `bus_rvalid`, and writes no RAM.
- R9: While `rst_n` is low, every strobe, `bus_rvalid`, `err_flag` and all held output bytes are zero.
- R10: `bus_rvalid` is high in exactly the cycle after each accepted read, and `bus_rdata` is 0x00 in every cycle in which `bus_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus cycle present |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_rvalid | output | 1 | Read data valid (cycle after a read) |
| bus_rdata | output | 8 | Read data |
| reg_rd_stb | output | 8 | One-hot graphics register read strobe |
| reg_wr_stb | output | 8 | One-hot graphics register write strobe |
| reg_wdata | output | 8 | Byte for the register being written |
| reg_rdata | input | 8 | Register read data, valid while `reg_rd_stb` is high |
| dma_start | output | 1 | Sprite DMA launch pulse |
| dma_page | output | 8 | DMA source page |
| map_req | output | 1 | Mapper access pulse |
| map_write | output | 1 | Mapper access direction |
| map_addr | output | 16 | Mapper address |
| map_wdata | output | 8 | Mapper write data |
| map_rdata | input | 8 | Mapper read data, valid while `map_req` is high |
| err_flag | output | 1 | Sticky illegal register access flag |

## Verification
Every result of this decoder is due exactly one clock after the bus cycle that causes it. This covers the strobes, `dma_start`, `map_req`, `bus_rvalid` with its data, and the setting of `err_flag`. Only the RAM write itself lands at the same edge. The bench drives each bus cycle on a falling edge. At the next falling edge, before it drives anything new, it compares every output against the prediction its model made for that cycle, using the responder bytes it presented alongside the request. An idle cycle, a reset or an illegal access is therefore checked in the very cycle in which a wrong pulse would appear.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

  // Region of the address map a bus cycle falls into.
  typedef enum logic [1:0] {
    REGN_RAM = 2'd0,
    REGN_GFX = 2'd1,
    REGN_IO  = 2'd2,
    REGN_MAP = 2'd3
  } region_e;

  // Source of the read data returned one cycle after a read.
  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_RAM  = 2'd1,
    SRC_REG  = 2'd2,
    SRC_MAP  = 2'd3
  } rsrc_e;

endpackage

// File: rtl/cbd_region_decode.sv
module cbd_region_decode
  import cbd_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned REG_AW = 3,
  parameter logic [ADDR_W-1:0] RAM_LIMIT = 16'h2000,
  parameter logic [ADDR_W-1:0] GFX_LIMIT = 16'h4000,
  parameter logic [ADDR_W-1:0] IO_LIMIT  = 16'h4020,
  parameter logic [ADDR_W-1:0] DMA_ADDR  = 16'h4014,
  parameter logic [(1<<REG_AW)-1:0] READ_OK  = 8'h94,
  parameter logic [(1<<REG_AW)-1:0] WRITE_OK = 8'hFB
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [REG_AW-1:0] reg_idx,
  output logic              rd_ok,
  output logic              wr_ok,
  output logic              is_dma
);

  // Region boundaries are ordered; the first limit that the address is below wins.
  always_comb begin
    if (addr < RAM_LIMIT)      region = REGN_RAM;
    else if (addr < GFX_LIMIT) region = REGN_GFX;
    else if (addr < IO_LIMIT)  region = REGN_IO;
    else                       region = REGN_MAP;
  end

  // The register window repeats on the low address bits.
  assign reg_idx = addr[REG_AW-1:0];
  assign rd_ok   = READ_OK[reg_idx];
  assign wr_ok   = WRITE_OK[reg_idx];
  assign is_dma  = (addr == DMA_ADDR);

endmodule

// File: rtl/cbd_work_ram.sv
module cbd_work_ram #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RAM_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [RAM_AW-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << RAM_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= mem[idx];
  end

  // R1: the read port only changes in the cycle after a read request.
  p_ram_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> $stable(rdata));

endmodule

// File: rtl/cbd_strobe_gen.sv
module cbd_strobe_gen
  import cbd_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned REG_AW = 3,
  parameter logic [ADDR_W-1:0] IO_LIMIT = 16'h4020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  region_e           region,
  input  logic [REG_AW-1:0] reg_idx,
  input  logic              rd_ok,
  input  logic              wr_ok,
  input  logic              is_dma,
  output logic [(1<<REG_AW)-1:0] reg_rd_stb,
  output logic [(1<<REG_AW)-1:0] reg_wr_stb,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              dma_start,
  output logic [DATA_W-1:0] dma_page,
  output logic              map_req,
  output logic              map_write,
  output logic [ADDR_W-1:0] map_addr,
  output logic [DATA_W-1:0] map_wdata,
  output logic              err_flag,
  output logic              rvalid,
  output rsrc_e             rd_src
);

  localparam int unsigned NREG = 1 << REG_AW;

  logic acc_rd, acc_wr, in_gfx;
  assign acc_rd = acc_valid && !acc_write;
  assign acc_wr = acc_valid && acc_write;
  assign in_gfx = (region == REGN_GFX);

  logic [NREG-1:0] rd_hit, wr_hit;

  // One decode slice per register index.
  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign rd_hit[g] = acc_rd && in_gfx && rd_ok && (reg_idx == REG_AW'(g));
    assign wr_hit[g] = acc_wr && in_gfx && wr_ok && (reg_idx == REG_AW'(g));
  end

  logic illegal, dma_fire, map_fire;
  assign illegal  = in_gfx && ((acc_rd && !rd_ok) || (acc_wr && !wr_ok));
  assign dma_fire = acc_wr && is_dma;
  assign map_fire = acc_valid && (region == REGN_MAP);

  rsrc_e src_nxt;
  always_comb begin
    src_nxt = SRC_ZERO;
    if (acc_rd) begin
      unique case (region)
        REGN_RAM: src_nxt = SRC_RAM;
        REGN_GFX: src_nxt = rd_ok ? SRC_REG : SRC_ZERO;
        REGN_MAP: src_nxt = SRC_MAP;
        default:  src_nxt = SRC_ZERO;
      endcase
    end
  end

  // Single-cycle pulses.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rd_stb <= '0;
      reg_wr_stb <= '0;
      dma_start  <= 1'b0;
      map_req    <= 1'b0;
      rvalid     <= 1'b0;
      rd_src     <= SRC_ZERO;
    end else begin
      reg_rd_stb <= rd_hit;
      reg_wr_stb <= wr_hit;
      dma_start  <= dma_fire;
      map_req    <= map_fire;
      rvalid     <= acc_rd;
      rd_src     <= src_nxt;
    end
  end

  // Held payloads, each refreshed only by its own event.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_wdata <= '0;
      dma_page  <= '0;
      map_write <= 1'b0;
      map_addr  <= '0;
      map_wdata <= '0;
    end else begin
      if (|wr_hit) reg_wdata <= wdata;
      if (dma_fire) dma_page <= wdata;
      if (map_fire) begin
        map_write <= acc_write;
        map_addr  <= addr;
        map_wdata <= wdata;
      end
    end
  end

  // Sticky error flag, cleared only by reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_flag <= 1'b0;
    else if (illegal) err_flag <= 1'b1;
  end

  p_rd_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_rd_stb));

  p_wr_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_wr_stb));

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  p_dma_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> $past(acc_valid && acc_write && is_dma));

  p_map_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    map_req |-> (map_addr >= IO_LIMIT));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(acc_valid) |-> (reg_rd_stb == '0 && reg_wr_stb == '0 &&
                           !map_req && !dma_start && !rvalid));

  p_rvalid_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(acc_valid && !acc_write));

endmodule

// File: rtl/cpu_bus_decoder.sv
module cpu_bus_decoder
  import cbd_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RAM_AW = 11,
  parameter int unsigned REG_AW = 3,
  parameter logic [ADDR_W-1:0] RAM_LIMIT = 16'h2000,
  parameter logic [ADDR_W-1:0] GFX_LIMIT = 16'h4000,
  parameter logic [ADDR_W-1:0] IO_LIMIT  = 16'h4020,
  parameter logic [ADDR_W-1:0] DMA_ADDR  = 16'h4014,
  parameter logic [(1<<REG_AW)-1:0] READ_OK  = 8'h94,
  parameter logic [(1<<REG_AW)-1:0] WRITE_OK = 8'hFB
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_valid,
  input  logic                   bus_write,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic                   bus_rvalid,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic [(1<<REG_AW)-1:0] reg_rd_stb,
  output logic [(1<<REG_AW)-1:0] reg_wr_stb,
  output logic [DATA_W-1:0]      reg_wdata,
  input  logic [DATA_W-1:0]      reg_rdata,
  output logic                   dma_start,
  output logic [DATA_W-1:0]      dma_page,
  output logic                   map_req,
  output logic                   map_write,
  output logic [ADDR_W-1:0]      map_addr,
  output logic [DATA_W-1:0]      map_wdata,
  input  logic [DATA_W-1:0]      map_rdata,
  output logic                   err_flag
);

  region_e           region;
  logic [REG_AW-1:0] reg_idx;
  logic              rd_ok, wr_ok, is_dma;
  rsrc_e             rd_src;
  logic [DATA_W-1:0] ram_q;
  logic              ram_wr, ram_rd;

  cbd_region_decode #(
    .ADDR_W(ADDR_W), .REG_AW(REG_AW),
    .RAM_LIMIT(RAM_LIMIT), .GFX_LIMIT(GFX_LIMIT), .IO_LIMIT(IO_LIMIT),
    .DMA_ADDR(DMA_ADDR), .READ_OK(READ_OK), .WRITE_OK(WRITE_OK)
  ) u_dec (
    .addr(bus_addr), .region(region), .reg_idx(reg_idx),
    .rd_ok(rd_ok), .wr_ok(wr_ok), .is_dma(is_dma)
  );

  assign ram_wr = bus_valid &&  bus_write && (region == REGN_RAM);
  assign ram_rd = bus_valid && !bus_write && (region == REGN_RAM);

  cbd_work_ram #(.DATA_W(DATA_W), .RAM_AW(RAM_AW)) u_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(ram_wr), .rd_en(ram_rd),
    .idx(bus_addr[RAM_AW-1:0]), .wdata(bus_wdata), .rdata(ram_q)
  );

  cbd_strobe_gen #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW), .IO_LIMIT(IO_LIMIT)
  ) u_stb (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(bus_valid), .acc_write(bus_write),
    .addr(bus_addr), .wdata(bus_wdata),
    .region(region), .reg_idx(reg_idx),
    .rd_ok(rd_ok), .wr_ok(wr_ok), .is_dma(is_dma),
    .reg_rd_stb(reg_rd_stb), .reg_wr_stb(reg_wr_stb), .reg_wdata(reg_wdata),
    .dma_start(dma_start), .dma_page(dma_page),
    .map_req(map_req), .map_write(map_write),
    .map_addr(map_addr), .map_wdata(map_wdata),
    .err_flag(err_flag), .rvalid(bus_rvalid), .rd_src(rd_src)
  );

  // Return path steered by the source registered with the request.
  always_comb begin
    unique case (rd_src)
      SRC_RAM: bus_rdata = ram_q;
      SRC_REG: bus_rdata = reg_rdata;
      SRC_MAP: bus_rdata = map_rdata;
      default: bus_rdata = '0;
    endcase
  end

  // R7: a mapper read is answered from the mapper port.
  p_map_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (map_req && !map_write) |-> (bus_rvalid && bus_rdata == map_rdata));

  // R2: a register read strobe comes with valid read data.
  p_reg_return_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_stb != '0) |-> (bus_rvalid && bus_rdata == reg_rdata));

endmodule

// File: tb/cpu_bus_decoder_test.sv
module cpu_bus_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0, reg_rdata = '0, map_rdata = '0;
  logic        bus_rvalid, dma_start, map_req, map_write, err_flag;
  logic [7:0]  bus_rdata, reg_rd_stb, reg_wr_stb, reg_wdata, dma_page, map_wdata;
  logic [15:0] map_addr;

  always #10 clk = ~clk;

  cpu_bus_decoder uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .reg_rd_stb(reg_rd_stb), .reg_wr_stb(reg_wr_stb),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_start(dma_start),
    .dma_page(dma_page), .map_req(map_req), .map_write(map_write),
    .map_addr(map_addr), .map_wdata(map_wdata), .map_rdata(map_rdata),
    .err_flag(err_flag)
  );

  int checks = 0, errors = 0;

  // Behavioural model state.
  byte unsigned ram_m [2048];
  logic        e_rvalid, e_dma, e_mreq, e_mwr, e_err;
  logic [7:0]  e_rdata, e_rd, e_wr, e_rwd, e_page, e_mwd;
  logic [15:0] e_maddr;
  string       e_tag;

  function automatic logic [68:0] act_vec();
    return {bus_rvalid, bus_rdata, reg_rd_stb, reg_wr_stb, reg_wdata, dma_start,
            dma_page, map_req, map_write, map_addr, map_wdata, err_flag};
  endfunction

  function automatic logic [68:0] exp_vec();
    return {e_rvalid, e_rdata, e_rd, e_wr, e_rwd, e_dma, e_page, e_mreq, e_mwr,
            e_maddr, e_mwd, e_err};
  endfunction

  task automatic compare();
    checks++;
    if (act_vec() !== exp_vec()) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", e_tag, $time, act_vec(), exp_vec());
    end
  endtask

  task automatic model_reset();
    e_rvalid = 0; e_rdata = 0; e_rd = 0; e_wr = 0; e_rwd = 0; e_dma = 0;
    e_page = 0; e_mreq = 0; e_mwr = 0; e_maddr = 0; e_mwd = 0; e_err = 0;
    e_tag = "R9";
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bus_valid = 0;
    model_reset();
    repeat (2) @(negedge clk);
    compare();               // R9 reset state
    rst_n = 1;
  endtask

  // One bus cycle: check the previous prediction, then drive and predict.
  task automatic cyc(input logic v, input logic w, input logic [15:0] a,
                     input logic [7:0] d);
    int unsigned idx;
    @(negedge clk);
    compare();
    reg_rdata = 8'($urandom);
    map_rdata = 8'($urandom);
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
    e_rvalid = v && !w; e_rdata = 0; e_rd = 0; e_wr = 0; e_dma = 0; e_mreq = 0;
    if (!v) e_tag = "R8";
    else if (a < 16'h2000) begin
      e_tag = "R1";
      if (w) ram_m[a & 16'h07FF] = d;
      else   e_rdata = ram_m[a & 16'h07FF];
    end else if (a < 16'h4000) begin
      idx = a & 16'h7;
      if (!w) begin
        if (idx == 2 || idx == 4 || idx == 7) begin
          e_rd = 8'(1 << idx); e_rdata = reg_rdata; e_tag = "R2";
        end else begin e_err = 1; e_tag = "R4"; end
      end else begin
        if (idx != 2) begin e_wr = 8'(1 << idx); e_rwd = d; e_tag = "R3"; end
        else begin e_err = 1; e_tag = "R4"; end
      end
    end else if (a < 16'h4020) begin
      if (w && a == 16'h4014) begin e_dma = 1; e_page = d; e_tag = "R5"; end
      else e_tag = "R6";
    end else begin
      e_mreq = 1; e_mwr = w; e_maddr = a; e_mwd = d; e_tag = "R7";
      if (!w) e_rdata = map_rdata;
    end
    if (v && !w) e_tag = {e_tag, " R10"};
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R8 watchdog: actual 200000 cycles expected completion earlier");
    finish_up();
  end

  initial begin
    do_reset();
    // R1: fill the whole RAM, then read through every mirror.
    for (int i = 0; i < 2048; i++) cyc(1, 1, 16'(i), 8'(i * 7 + 3));
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 24; i++) cyc(1, 0, 16'(m * 16'h800 + i * 85), 8'h00);
    cyc(1, 1, 16'h1FFF, 8'hA5);            // R1 top mirror write
    cyc(1, 0, 16'h07FF, 8'h00);            // R1 aliased read
    cyc(0, 1, 16'h0005, 8'h11);            // R8 idle write, no RAM change
    cyc(1, 0, 16'h0005, 8'h00);
    // R2 / R3 legal register traffic, low and high mirrors.
    foreach (bus_addr[k]) if (k < 8) begin
      if (k == 2 || k == 4 || k == 7) begin
        cyc(1, 0, 16'(16'h2000 + k), 8'h00);
        cyc(1, 0, 16'(16'h3FF8 + k), 8'h00);
      end else begin
        cyc(1, 1, 16'(16'h2000 + k), 8'(8'h40 + k));
        cyc(1, 1, 16'(16'h3AB8 + k), 8'(8'hC0 + k));
      end
    end
    cyc(1, 1, 16'h2004, 8'h5A);            // R3 index 4
    cyc(1, 1, 16'h2007, 8'h6B);            // R3 index 7
    // R5 DMA then R6 dummies.
    cyc(1, 1, 16'h4014, 8'h02);
    cyc(1, 1, 16'h4014, 8'h07);            // back-to-back launches
    for (int i = 0; i < 32; i++) cyc(1, 1, 16'(16'h4000 + i), 8'hEE);
    for (int i = 0; i < 32; i++) cyc(1, 0, 16'(16'h4000 + i), 8'h00);
    cyc(1, 0, 16'h0005, 8'h00);            // R6 RAM untouched
    // R7 mapper boundaries.
    cyc(1, 0, 16'h4020, 8'h00);
    cyc(1, 1, 16'h4020, 8'h99);
    cyc(1, 1, 16'hFFFF, 8'h12);
    cyc(1, 0, 16'h8000, 8'h00);
    cyc(0, 0, 16'h8000, 8'h00);            // R8 map outputs hold
    // R4 illegal accesses, then reset clears the flag.
    cyc(1, 0, 16'h2000, 8'h00);
    cyc(1, 1, 16'h2002, 8'h33);
    cyc(1, 0, 16'h3FFE, 8'h00);
    cyc(0, 0, 16'h0000, 8'h00);
    do_reset();                            // R9 err cleared
    cyc(1, 0, 16'h0005, 8'h00);            // RAM survives reset
    // Mixed traffic.
    for (int n = 0; n < 4000; n++) begin
      int unsigned r = $urandom % 5;
      logic w = 1'($urandom);
      logic [15:0] a;
      case (r)
        0: a = 16'($urandom % 16'h2000);
        1: a = 16'(16'h2000 + $urandom % 16'h2000);
        2: a = 16'(16'h4000 + $urandom % 32);
        3: a = 16'(16'h4020 + $urandom % 16'hBFE0);
        default: a = 16'($urandom);
      endcase
      cyc(r != 4 || ($urandom % 2 == 0), w, a, 8'($urandom));
    end
    cyc(0, 0, 16'h0000, 8'h00);
    @(negedge clk);
    compare();
    finish_up();
  end

endmodule